// File: doc/BRIEF.md
# UART Hardware Flow Control Unit

This block carries out the hardware handshake for one asynchronous serial port. It sits between the port's holding registers and its shift logic. It decides when the transmitter may begin a frame, whether the receiver is enabled, and what level the outgoing handshake pin shows. The port has two shared handshake pins, and each one has two roles.

The incoming pin is active low. A role bit selects its job. With the bit at 0 the pin is a clear-to-send input that gates frame starts. With the bit at 1 it is a receiver-enable request. The pin passes through a synchronizer first.

The outgoing pin is also active low. A second role bit selects its job. With the bit at 1 it is a ready-to-send output that reflects a full transmit register. With the bit at 0 it is a ready-to-receive output that reflects an empty receive register.

A master enable turns all flow control off. When it is off, frames start freely, the receiver stays enabled and the outgoing pin stays high. Clear-to-send is only consulted while the transmitter is idle, that is, at a frame boundary. A frame that has begun runs until the transmitter reports that it is done.

Top module: `uart_hs_ctrl`

## Requirements
- R1: While `rst` is high, and on the first cycle after it is released, `tx_start` is 0, `rx_enable` is 1 and `hs_out_n` is 1.
- R2: With `fc_en` at 0, a frame starts on the first rising edge that sees `tx_full` at 1, whatever the level of `hs_in_n`. Also, `rx_enable` is 1 and `hs_out_n` is 1 one edge after `fc_en` is sampled at 0.
- R3: With `fc_en`=1 and `in_role`=0 (clear-to-send), the synchronized pin must read 0 for a frame to start. While the pin reads 1, the data stays held and `tx_start` stays 0. No frame ever starts without `tx_full` sampled at 1.
- R4: A held frame is re-tried on every clock. It starts on the first edge at which the synchronized pin reads 0.
- R5: Once a frame has started, no further `tx_start` is issued until a `frame_done` pulse has been sampled. A pin change in mid-frame has no effect. After `frame_done`, a pending frame starts one edge later.
- R6: `tx_start` is a single-cycle pulse.
- R7: With `fc_en`=1 and `in_role`=1 (receiver enable), `rx_enable` follows the synchronized pin inverted. In this mode the transmitter is not gated by the pin.
- R8: With `fc_en`=1 and `in_role`=0, `rx_enable` is 1.
- R9: With `fc_en`=1 and `out_role`=1 (ready-to-send), `hs_out_n` is 0 one edge after `tx_full` is sampled at 1, and 1 one edge after it is sampled at 0.
- R10: With `fc_en`=1 and `out_role`=0 (ready-to-receive), one edge after sampling, `hs_out_n` equals the sampled `rx_valid`. It is therefore 0 while no unread data is held.
- R11: `hs_in_n` passes through `SYNC_STAGES` (default 2) flops. A change driven before edge d first shows at the outputs after edge d+SYNC_STAGES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fc_en | input | 1 | Flow control enable |
| in_role | input | 1 | Input pin role: 0 clear-to-send, 1 receiver enable |
| out_role | input | 1 | Output pin role: 1 ready-to-send, 0 ready-to-receive |
| hs_in_n | input | 1 | Asynchronous handshake input, active low |
| tx_full | input | 1 | Transmit register holds untransmitted data |
| rx_valid | input | 1 | Receive register holds unread data |
| frame_done | input | 1 | One-cycle pulse from the transmitter at frame end |
| tx_start | output | 1 | One-cycle permission to begin a frame |
| rx_enable | output | 1 | Receiver enable |
| hs_out_n | output | 1 | Handshake output, active low |

## Verification
The assertions check four things on every cycle: that `tx_start` is a single pulse, that a start never comes without transmit data, that no second start occurs before `frame_done`, and that the outgoing pin and the receiver enable match their role rules and the disabled state. The bench scenarios are needed for the timing questions. Those are the exact cycle at which a held frame is released after the pin asserts, the synchronizer latency seen at the outputs, and the absence of any start while clear-to-send stays deasserted or a frame is still open.

// File: rtl/uart_hs_pkg.sv
package uart_hs_pkg;
  typedef enum logic {TX_IDLE = 1'b0, TX_BUSY = 1'b1} tx_state_t;
endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
  parameter int STAGES = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[i] <= RST_VAL;
      else if (i == 0) chain[i] <= d_async;
      else chain[i] <= chain[(i == 0) ? 0 : i-1];
    end
  end

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/hs_tx_gate.sv
module hs_tx_gate
  import uart_hs_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic fc_en,
  input  logic in_role,
  input  logic pin_sync_n,
  input  logic tx_full,
  input  logic frame_done,
  output logic tx_start
);
  tx_state_t state;
  logic      permit;

  // Clear-to-send only matters while idle, i.e. at a frame boundary.
  assign permit = !fc_en || in_role || !pin_sync_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= TX_IDLE;
      tx_start <= 1'b0;
    end else begin
      tx_start <= 1'b0;
      case (state)
        TX_IDLE: if (tx_full && permit) begin
          tx_start <= 1'b1;
          state    <= TX_BUSY;
        end
        TX_BUSY: if (frame_done) state <= TX_IDLE;
        default: state <= TX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hs_pin_ctrl.sv
module hs_pin_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic fc_en,
  input  logic in_role,
  input  logic out_role,
  input  logic pin_sync_n,
  input  logic tx_full,
  input  logic rx_valid,
  output logic rx_enable,
  output logic hs_out_n
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rx_enable <= 1'b1;
      hs_out_n  <= 1'b1;
    end else begin
      rx_enable <= !fc_en || !in_role || !pin_sync_n;
      if (!fc_en)       hs_out_n <= 1'b1;
      else if (out_role) hs_out_n <= !tx_full;
      else              hs_out_n <= rx_valid;
    end
  end
endmodule

// File: rtl/uart_hs_ctrl.sv
module uart_hs_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic fc_en,
  input  logic in_role,
  input  logic out_role,
  input  logic hs_in_n,
  input  logic tx_full,
  input  logic rx_valid,
  input  logic frame_done,
  output logic tx_start,
  output logic rx_enable,
  output logic hs_out_n
);
  logic pin_sync_n;

  hs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst(rst), .d_async(hs_in_n), .q_sync(pin_sync_n)
  );

  hs_tx_gate u_tx (
    .clk(clk), .rst(rst), .fc_en(fc_en), .in_role(in_role),
    .pin_sync_n(pin_sync_n), .tx_full(tx_full), .frame_done(frame_done),
    .tx_start(tx_start)
  );

  hs_pin_ctrl u_pin (
    .clk(clk), .rst(rst), .fc_en(fc_en), .in_role(in_role),
    .out_role(out_role), .pin_sync_n(pin_sync_n), .tx_full(tx_full),
    .rx_valid(rx_valid), .rx_enable(rx_enable), .hs_out_n(hs_out_n)
  );
endmodule

// File: rtl/uart_hs_ctrl_chk.sv
module uart_hs_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic fc_en,
  input logic in_role,
  input logic out_role,
  input logic tx_full,
  input logic rx_valid,
  input logic frame_done,
  input logic tx_start,
  input logic rx_enable,
  input logic hs_out_n
);
  logic armed;
  logic open_frame;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed      <= 1'b0;
      open_frame <= 1'b0;
    end else begin
      armed <= 1'b1;
      if (tx_start) open_frame <= 1'b1;
      else if (frame_done) open_frame <= 1'b0;
    end
  end

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
    tx_start |=> !tx_start);
  a_r3_needs_data: assert property (@(posedge clk) disable iff (rst)
    (armed && tx_start) |-> $past(tx_full));
  a_r5_no_restart: assert property (@(posedge clk) disable iff (rst)
    tx_start |-> !open_frame);
  a_r2_out_idle: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(!fc_en)) |-> hs_out_n);
  a_r2_rx_free: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(!fc_en)) |-> rx_enable);
  a_r8_rx_cts_mode: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(fc_en && !in_role)) |-> rx_enable);
  a_r9_rts_level: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(fc_en && out_role)) |-> (hs_out_n == !$past(tx_full)));
  a_r10_rtr_level: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(fc_en && !out_role)) |-> (hs_out_n == $past(rx_valid)));
endmodule

bind uart_hs_ctrl uart_hs_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .fc_en(fc_en), .in_role(in_role),
  .out_role(out_role), .tx_full(tx_full), .rx_valid(rx_valid),
  .frame_done(frame_done), .tx_start(tx_start), .rx_enable(rx_enable),
  .hs_out_n(hs_out_n)
);

// File: tb/sim_uart_hs_ctrl.sv
module sim_uart_hs_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fc_en = 1'b0, in_role = 1'b0, out_role = 1'b0;
  logic hs_in_n = 1'b1, tx_full = 1'b0, rx_valid = 1'b0, frame_done = 1'b0;
  logic tx_start, rx_enable, hs_out_n;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  typedef struct { int at; string req; } exp_t;
  exp_t exp_q[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  uart_hs_ctrl u0 (
    .clk(clk), .rst(rst), .fc_en(fc_en), .in_role(in_role),
    .out_role(out_role), .hs_in_n(hs_in_n), .tx_full(tx_full),
    .rx_valid(rx_valid), .frame_done(frame_done), .tx_start(tx_start),
    .rx_enable(rx_enable), .hs_out_n(hs_out_n)
  );

  task automatic chk(input logic got, input logic expv, input string req);
    checks++;
    if (got !== expv) begin
      errors++;
      $display("FAIL %s cycle %0d: got %b expected %b", req, cyc, got, expv);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_start(input int at, input string req);
    exp_t e;
    e.at = at;
    e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic wait_start();
    while (tx_start !== 1'b1) @(negedge clk);
    tx_full = 1'b0;
  endtask

  task automatic end_frame();
    tick(2);
    frame_done = 1'b1;
    tick(1);
    frame_done = 1'b0;
    tick(1);
  endtask

  // Monitor: every start pulse must match the next expected item.
  always @(negedge clk) begin
    if (!rst && tx_start === 1'b1) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R3/R5 unexpected start at cycle %0d: got start expected none", cyc);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (e.at != cyc) begin
          errors++;
          $display("FAIL %s start cycle: got %0d expected %0d", e.req, cyc, e.at);
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int mark;
    tick(3);
    // R1 reset state
    chk(tx_start, 1'b0, "R1 tx_start in reset");
    chk(rx_enable, 1'b1, "R1 rx_enable in reset");
    chk(hs_out_n, 1'b1, "R1 hs_out_n in reset");
    rst = 1'b0;
    tick(1);
    chk(tx_start, 1'b0, "R1 tx_start after reset");
    chk(hs_out_n, 1'b1, "R1 hs_out_n after reset");

    // R2 flow control off: free start, pin ignored, idle output
    out_role = 1'b1;
    hs_in_n = 1'b1;
    tick(4);
    tx_full = 1'b1;
    expect_start(cyc + 1, "R2");
    wait_start();
    chk(hs_out_n, 1'b1, "R2 hs_out_n with fc off");
    chk(rx_enable, 1'b1, "R2 rx_enable with fc off");
    end_frame();

    // R3 clear-to-send held off
    fc_en = 1'b1; in_role = 1'b0; out_role = 1'b0; rx_valid = 1'b1;
    tick(4);
    chk(rx_enable, 1'b1, "R8 rx_enable in cts mode");
    tx_full = 1'b1;
    tick(6);
    chk(tx_start, 1'b0, "R3 held while cts deasserted");
    // R4 / R11 release after synchronizer latency
    hs_in_n = 1'b0;
    expect_start(cyc + 3, "R4 R11");
    wait_start();
    // R5 mid-frame pin change, new data waits for frame_done
    hs_in_n = 1'b1;
    tick(2);
    tx_full = 1'b1;
    tick(5);
    chk(tx_start, 1'b0, "R5 no start during open frame");
    hs_in_n = 1'b0;
    tick(4);
    chk(tx_start, 1'b0, "R5 no start before frame_done");
    frame_done = 1'b1;
    expect_start(cyc + 2, "R5");
    tick(1);
    frame_done = 1'b0;
    wait_start();
    end_frame();

    // R9 ready-to-send with data held by cts
    hs_in_n = 1'b1; out_role = 1'b1;
    tick(4);
    tx_full = 1'b1;
    tick(1);
    chk(hs_out_n, 1'b0, "R9 rts asserted with data");
    tick(3);
    chk(tx_start, 1'b0, "R3 held in rts scenario");
    tx_full = 1'b0;
    tick(1);
    chk(hs_out_n, 1'b1, "R9 rts released when empty");

    // R10 ready-to-receive
    out_role = 1'b0; rx_valid = 1'b1;
    tick(1);
    chk(hs_out_n, 1'b1, "R10 rtr off with unread data");
    rx_valid = 1'b0;
    tick(1);
    chk(hs_out_n, 1'b0, "R10 rtr on when empty");

    // R7 receiver-enable mode, transmitter ungated
    in_role = 1'b1; hs_in_n = 1'b1;
    tick(4);
    chk(rx_enable, 1'b0, "R7 receiver disabled by pin");
    tx_full = 1'b1;
    expect_start(cyc + 1, "R7");
    wait_start();
    end_frame();
    // R11 exact latency
    hs_in_n = 1'b0;
    mark = cyc;
    tick(2);
    chk(rx_enable, 1'b0, "R11 before latency");
    tick(1);
    chk(rx_enable, 1'b1, "R11 at latency");
    if (cyc != mark + 3) chk(1'b0, 1'b1, "R11 cycle count");

    // R2 output idle when disabled with rts role and data
    fc_en = 1'b0; out_role = 1'b1; hs_in_n = 1'b1;
    tick(1);
    chk(hs_out_n, 1'b1, "R2 output idle when disabled");

    tick(3);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R3 pending starts: got %0d expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule